// File: doc/BRIEF.md
# Receive Destination Address Filter

This block watches the first six bytes of every received Ethernet frame, which carry the destination address, and decides whether the frame should be kept. The bytes enter one per clock on a byte stream. A start-of-frame flag travels with the first byte. The accept decision depends on two settings: a 2-bit policy selector and a 48-bit station address held outside the block.

The filter never holds back the stream. `in_ready` stays high at all times, and a byte is consumed on every cycle where `in_valid` is high. Idle cycles may sit between address bytes without harm. The settings in force for a frame are the ones present on the start-of-frame byte. The verdict comes back on the plain pins `dec_valid` and `dec_accept` as a one-cycle pulse.

Policy codes on `cfg_mode`:
- 0: drop everything.
- 1: keep exact station matches only.
- 2: keep station matches and the all-ones broadcast address.
- 3: keep everything.

Top module: `rx_daddr_filter`

## Requirements
- R1: After reset, `dec_valid` is low and `in_ready` is high.
- R2: `dec_valid` is high for exactly one cycle, namely the cycle after the clock edge that consumes the sixth address byte of a frame; it is low at all other times.
- R3: With `cfg_mode` = 0 at start of frame, `dec_accept` is low on the decision pulse whatever the address.
- R4: With `cfg_mode` = 1, the frame is accepted only when all six address bytes equal the station address; the broadcast address is rejected unless it is the station address.
- R5: With `cfg_mode` = 2, the frame is accepted when it equals the station address or when all six bytes are 0xFF.
- R6: With `cfg_mode` = 3, every frame is accepted.
- R7: Address byte k (k = 0 first on the wire) is compared with `cfg_station[8k+7:8k]`.
- R8: A byte with `in_valid` and `in_sof` both high always starts a new address, even partway through one; the cut-off address produces no decision.
- R9: `cfg_mode` and `cfg_station` are sampled on the start-of-frame byte; later changes during that frame do not alter its decision.
- R10: Bytes after the sixth, and bytes with no start-of-frame since reset, produce no decision pulse until the next start-of-frame byte.
- R11: Cycles with `in_valid` low do not advance the address, even if `in_sof` is high on them.
- R12: `in_ready` is high in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_mode | input | 2 | Accept policy code (0..3) |
| cfg_station | input | 48 | Station address, byte k at bits 8k+7:8k |
| in_valid | input | 1 | Byte present on `in_data` |
| in_sof | input | 1 | Qualified by `in_valid`: this byte is the first of a frame |
| in_data | input | 8 | Received byte |
| in_ready | output | 1 | Always high; the filter never stalls |
| dec_valid | output | 1 | One-cycle decision pulse |
| dec_accept | output | 1 | Verdict, meaningful while `dec_valid` is high, low otherwise |

## Verification
The only timed result is the decision. It is due in the cycle after the edge that takes the sixth valid byte, with no delay from idle gaps earlier in the address. The bench drives inputs on the falling edge and samples `dec_valid` and `dec_accept` on the falling edge that follows the consuming rising edge. It checks the pulse there and checks that the pulse is gone one falling edge later. After every earlier or surplus byte, the bench confirms that `dec_valid` is low at that same sampling point.

// File: rtl/rdf_pkg.sv
package rdf_pkg;
  typedef enum logic [1:0] {
    ACC_NONE        = 2'd0,
    ACC_EXACT       = 2'd1,
    ACC_EXACT_BCAST = 2'd2,
    ACC_ALL         = 2'd3
  } acc_mode_e;

  localparam int unsigned DEF_ADDR_BYTES = 6;
  localparam int unsigned DEF_BYTE_W     = 8;
endpackage

// File: rtl/rdf_byte_seq.sv
// Tracks position inside the destination address of the current frame.
module rdf_byte_seq #(
  parameter int unsigned ADDR_BYTES = 6,
  localparam int unsigned CNT_W = $clog2(ADDR_BYTES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             in_sof,
  output logic             take,
  output logic             first,
  output logic             last,
  output logic [CNT_W-1:0] idx
);
  logic [CNT_W-1:0] cnt;
  logic             mid;

  // cnt == 0: no frame seen; cnt == ADDR_BYTES: address complete
  assign mid   = (cnt != '0) && (cnt < CNT_W'(ADDR_BYTES));
  assign first = in_valid && in_sof;
  assign take  = first || (in_valid && mid);
  assign idx   = first ? '0 : cnt;
  assign last  = take && (idx == CNT_W'(ADDR_BYTES - 1));

  always_ff @(posedge clk) begin
    if (!rst_n)    cnt <= '0;
    else if (take) cnt <= idx + CNT_W'(1);
  end
endmodule

// File: rtl/rdf_cfg_snap.sv
// Holds the policy and station address seen on the start-of-frame byte.
module rdf_cfg_snap #(
  parameter int unsigned ADDR_BYTES = 6,
  parameter int unsigned BYTE_W     = 8,
  localparam int unsigned ST_W = ADDR_BYTES * BYTE_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                first,
  input  rdf_pkg::acc_mode_e  cfg_mode,
  input  logic [ST_W-1:0]     cfg_station,
  output rdf_pkg::acc_mode_e  eff_mode,
  output logic [ST_W-1:0]     eff_station
);
  rdf_pkg::acc_mode_e snap_mode;
  logic [ST_W-1:0]    snap_station;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      snap_mode    <= rdf_pkg::ACC_NONE;
      snap_station <= '0;
    end else if (first) begin
      snap_mode    <= cfg_mode;
      snap_station <= cfg_station;
    end
  end

  // the start byte itself sees live settings, which are the ones being captured
  assign eff_mode    = first ? cfg_mode    : snap_mode;
  assign eff_station = first ? cfg_station : snap_station;
endmodule

// File: rtl/rdf_addr_cmp.sv
// Running exact-match and all-ones tests over the address bytes.
module rdf_addr_cmp #(
  parameter int unsigned ADDR_BYTES = 6,
  parameter int unsigned BYTE_W     = 8,
  localparam int unsigned ST_W  = ADDR_BYTES * BYTE_W,
  localparam int unsigned CNT_W = $clog2(ADDR_BYTES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic              first,
  input  logic [CNT_W-1:0]  idx,
  input  logic [BYTE_W-1:0] data,
  input  logic [ST_W-1:0]   ref_station,
  output logic              uc_final,
  output logic              bc_final
);
  logic [ADDR_BYTES-1:0] lane_hit;
  logic                  eq_sel, is_ones;
  logic                  uc_run, bc_run;

  for (genvar k = 0; k < ADDR_BYTES; k++) begin : g_lane
    assign lane_hit[k] = (idx == CNT_W'(k)) &&
                         (data == ref_station[k*BYTE_W +: BYTE_W]);
  end

  assign eq_sel   = |lane_hit;
  assign is_ones  = &data;
  assign uc_final = (first || uc_run) && eq_sel;
  assign bc_final = (first || bc_run) && is_ones;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      uc_run <= 1'b0;
      bc_run <= 1'b0;
    end else if (take) begin
      uc_run <= uc_final;
      bc_run <= bc_final;
    end
  end
endmodule

// File: rtl/rx_daddr_filter.sv
module rx_daddr_filter #(
  parameter int unsigned ADDR_BYTES = rdf_pkg::DEF_ADDR_BYTES,
  parameter int unsigned BYTE_W     = rdf_pkg::DEF_BYTE_W,
  localparam int unsigned ST_W  = ADDR_BYTES * BYTE_W,
  localparam int unsigned CNT_W = $clog2(ADDR_BYTES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        cfg_mode,
  input  logic [ST_W-1:0]   cfg_station,
  input  logic              in_valid,
  input  logic              in_sof,
  input  logic [BYTE_W-1:0] in_data,
  output logic              in_ready,
  output logic              dec_valid,
  output logic              dec_accept
);
  logic               take, first, last;
  logic [CNT_W-1:0]   idx;
  rdf_pkg::acc_mode_e eff_mode;
  logic [ST_W-1:0]    eff_station;
  logic               uc_final, bc_final, verdict;

  assign in_ready = 1'b1;

  rdf_byte_seq #(.ADDR_BYTES(ADDR_BYTES)) u_seq (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof),
    .take(take), .first(first), .last(last), .idx(idx)
  );

  rdf_cfg_snap #(.ADDR_BYTES(ADDR_BYTES), .BYTE_W(BYTE_W)) u_snap (
    .clk(clk), .rst_n(rst_n), .first(first),
    .cfg_mode(rdf_pkg::acc_mode_e'(cfg_mode)), .cfg_station(cfg_station),
    .eff_mode(eff_mode), .eff_station(eff_station)
  );

  rdf_addr_cmp #(.ADDR_BYTES(ADDR_BYTES), .BYTE_W(BYTE_W)) u_cmp (
    .clk(clk), .rst_n(rst_n), .take(take), .first(first), .idx(idx),
    .data(in_data), .ref_station(eff_station),
    .uc_final(uc_final), .bc_final(bc_final)
  );

  always_comb begin
    unique case (eff_mode)
      rdf_pkg::ACC_NONE:        verdict = 1'b0;
      rdf_pkg::ACC_EXACT:       verdict = uc_final;
      rdf_pkg::ACC_EXACT_BCAST: verdict = uc_final || bc_final;
      rdf_pkg::ACC_ALL:         verdict = 1'b1;
      default:                  verdict = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dec_valid  <= 1'b0;
      dec_accept <= 1'b0;
    end else begin
      dec_valid  <= last;
      dec_accept <= last && verdict;
    end
  end
endmodule

// File: rtl/rdf_chk.sv
module rdf_chk #(
  parameter int unsigned ADDR_BYTES = 6
) (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] cfg_mode,
  input logic       in_valid,
  input logic       in_sof,
  input logic       dec_valid,
  input logic       dec_accept
);
  localparam int unsigned CW = $clog2(ADDR_BYTES + 1);
  logic [CW-1:0] ck_cnt;
  logic [1:0]    ck_mode;
  logic          ck_fire;

  assign ck_fire = in_valid && !in_sof && (ck_cnt == CW'(ADDR_BYTES - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ck_cnt  <= '0;
      ck_mode <= 2'd0;
    end else if (in_valid && in_sof) begin
      ck_cnt  <= CW'(1);
      ck_mode <= cfg_mode;
    end else if (in_valid && ck_cnt != '0 && ck_cnt < CW'(ADDR_BYTES)) begin
      ck_cnt  <= ck_cnt + CW'(1);
    end
  end

  // R2
  last_byte_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ck_fire |=> dec_valid);
  // R2
  pulse_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid |-> $past(ck_fire));
  // R11
  pulse_after_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid |-> $past(in_valid));
  // R3
  mode_none_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && ck_mode == 2'd0) |-> !dec_accept);
  // R6
  mode_all_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && ck_mode == 2'd3) |-> dec_accept);
  // R2
  accept_only_on_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dec_accept |-> dec_valid);
endmodule

bind rx_daddr_filter rdf_chk #(.ADDR_BYTES(ADDR_BYTES)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .in_valid(in_valid),
  .in_sof(in_sof), .dec_valid(dec_valid), .dec_accept(dec_accept)
);

// File: tb/tb_rx_daddr_filter.sv
`timescale 1ns/1ps
module tb_rx_daddr_filter;
  localparam real CLK_NS = 8.0;
  localparam logic [47:0] BCAST = 48'hFFFF_FFFF_FFFF;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  cfg_mode = 2'd0;
  logic [47:0] cfg_station = '0;
  logic        in_valid = 1'b0, in_sof = 1'b0;
  logic [7:0]  in_data = '0;
  logic        in_ready, dec_valid, dec_accept;

  int checks = 0, errors = 0;
  bit done = 0;

  always #(CLK_NS/2) clk = ~clk;

  rx_daddr_filter dut (
    .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_station(cfg_station),
    .in_valid(in_valid), .in_sof(in_sof), .in_data(in_data),
    .in_ready(in_ready), .dec_valid(dec_valid), .dec_accept(dec_accept)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit exp_accept(input logic [1:0] m, input logic [47:0] st,
                                    input logic [47:0] d);
    case (m)
      2'd0: return 1'b0;
      2'd1: return d == st;
      2'd2: return (d == st) || (d == BCAST);
      default: return 1'b1;
    endcase
  endfunction

  // idle gap cycles (optionally with a lone sof), then one valid byte; returns at the
  // falling edge after the consuming rising edge
  task automatic drive(input logic [7:0] d, input bit sof, input int gap, input bit ghost);
    for (int g = 0; g < gap; g++) begin
      in_valid = 1'b0; in_sof = ghost;
      @(negedge clk);
    end
    in_valid = 1'b1; in_sof = sof; in_data = d;
    @(negedge clk);
    in_valid = 1'b0; in_sof = 1'b0;
  endtask

  task automatic run_frame(input string req, input logic [1:0] m, input logic [47:0] st,
                           input logic [47:0] d, input int maxgap, input bit perturb,
                           input bit ghost);
    bit early = 0;
    cfg_mode = m; cfg_station = st;
    for (int i = 0; i < 6; i++) begin
      drive(d[8*i +: 8], i == 0, (maxgap > 0) ? int'($urandom % (maxgap + 1)) : 0,
            ghost && i == 3);
      if (i == 0 && perturb) begin cfg_mode = ~m; cfg_station = ~st; end
      if (i < 5 && dec_valid) early = 1;
    end
    check({req, " R2 pulse on sixth byte"}, dec_valid, 1'b1);
    check({req, " verdict"}, dec_accept, exp_accept(m, st, d));
    check({req, " R2 no early pulse"}, early, 1'b0);
    @(negedge clk);
    check({req, " R2 single cycle"}, dec_valid, 1'b0);
  endtask

  localparam logic [47:0] ST_A = 48'h5544_3322_1100;

  initial begin
    bit quiet;
    logic [47:0] st, d;
    logic [1:0]  m;
    void'($urandom(32'h0BAD_5EED));
    repeat (3) @(negedge clk);
    check("R1 dec_valid after reset", dec_valid, 1'b0);
    check("R1 in_ready after reset", in_ready, 1'b1);
    rst_n = 1'b1;
    @(negedge clk);

    // R10: bytes with no start-of-frame since reset
    quiet = 1;
    for (int i = 0; i < 8; i++) begin
      drive(8'(i), 1'b0, 0, 1'b0);
      if (dec_valid) quiet = 0;
    end
    check("R10 no pulse before first sof", quiet, 1'b1);

    run_frame("R4 exact match", 2'd1, ST_A, ST_A, 0, 0, 0);
    run_frame("R4 broadcast rejected", 2'd1, ST_A, BCAST, 0, 0, 0);
    run_frame("R5 broadcast", 2'd2, ST_A, BCAST, 1, 0, 0);
    run_frame("R5 station", 2'd2, ST_A, ST_A, 1, 0, 0);
    run_frame("R5 other", 2'd2, ST_A, 48'h1234_5678_9ABC, 0, 0, 0);
    run_frame("R5 near broadcast", 2'd2, ST_A, 48'hFFFF_FFFF_FFFE, 0, 0, 0);
    run_frame("R3 drop matching", 2'd0, ST_A, ST_A, 0, 0, 0);
    run_frame("R3 drop broadcast", 2'd0, ST_A, BCAST, 0, 0, 0);
    run_frame("R6 any address", 2'd3, ST_A, 48'h0000_0000_0001, 0, 0, 0);
    run_frame("R7 byte order", 2'd1, ST_A, 48'h0011_2233_4455, 0, 0, 0);
    run_frame("R7 last byte differs", 2'd1, ST_A, ST_A ^ 48'h0100_0000_0000, 0, 0, 0);
    run_frame("R9 cfg change mid-frame", 2'd1, ST_A, ST_A, 0, 1, 0);
    run_frame("R9 cfg change to promisc", 2'd0, ST_A, BCAST, 0, 1, 0);
    run_frame("R11 ghost sof in gap", 2'd1, ST_A, ST_A, 2, 0, 1);

    // R10: surplus bytes after the sixth
    quiet = 1;
    for (int i = 0; i < 5; i++) begin
      drive(8'hFF, 1'b0, i % 2, 1'b0);
      if (dec_valid) quiet = 0;
    end
    check("R10 surplus bytes ignored", quiet, 1'b1);

    // R8: restart partway through an address
    cfg_mode = 2'd1; cfg_station = ST_A;
    quiet = 1;
    for (int i = 0; i < 4; i++) begin
      drive(8'hFF, i == 0, 0, 1'b0);
      if (dec_valid) quiet = 0;
    end
    check("R8 cut-off address no pulse", quiet, 1'b1);
    run_frame("R8 restart", 2'd1, ST_A, ST_A, 0, 0, 0);

    // random frames
    for (int n = 0; n < 300; n++) begin
      st = {$urandom, $urandom};
      m  = 2'($urandom % 4);
      case ($urandom % 4)
        0: d = st;
        1: d = BCAST;
        2: d = {$urandom, $urandom};
        default: d = st ^ (48'(($urandom % 255) + 1) << (8 * ($urandom % 6)));
      endcase
      run_frame("R4 R5 R6 random", m, st, d, 2, ($urandom % 4) == 0, ($urandom % 4) == 0);
      if (n % 50 == 0) check("R12 in_ready", in_ready, 1'b1);
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_NS * 200000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule